// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block holds in-flight instructions in program order between issue and retirement. Issue reserves one slot per cycle and receives that slot's index as the destination tag. Execution units later broadcast a tag together with its result, and the matching slot captures the value. Only the oldest slot may retire, and only once its result has arrived. Retirement presents the register write or the store to the outside. As a result, architectural registers and memory change strictly in program order.

Each slot also carries a wrong-path flag and a fault flag. Neither flag acts when it is written. The block only inspects them when the slot becomes the oldest. A flagged oldest slot discards every younger slot and steers fetch to a new address. For a wrong-path branch that address is the correct target. For a fault it is a fixed trap vector. An operand lookup port lets dispatch read any finished result that has not yet retired.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `commit_valid`, `flush`, `exc_valid` and every `fwd_valid` are 0.
- R2: Tags are handed out as consecutive slot indices modulo DEPTH, continuing across wraps. `alloc_ready` is 0 while DEPTH slots are held. A request made while `alloc_ready` is 0 is ignored and does not move the next tag.
- R3: A write-back to a held slot stores its data, aux, wrong-path, fault and cause fields and marks the slot ready. A write-back to a free slot is ignored, so that slot does not read as ready once it is allocated.
- R4: `commit_valid` is 1 only for the oldest held slot and only once its result is present. A ready younger slot waits until every older slot has retired.
- R5: A normal retirement drives `commit_dst`, `commit_data`, `commit_pc` and `commit_aux` from the slot. `commit_reg_we` is 1 when the slot was allocated with `alloc_wr`. `commit_st_we` is 1 when the slot was allocated with `alloc_st`, and `commit_aux` then carries the store address.
- R6: `fwd_valid` is 1 exactly when the slot at `fwd_tag` is held and ready, and `fwd_data` then equals its result.
- R7: When the oldest slot retires with the wrong-path flag set and no fault, `flush` is 1 and `redirect_pc` equals the slot's aux value, and its register write still happens. From the next cycle the buffer is empty, and the next tag is the slot after the flushed one.
- R8: When the oldest slot holds a fault, `flush` and `exc_valid` are 1 and `redirect_pc` equals TRAP_VECTOR, even if the wrong-path flag is also set. Neither `commit_reg_we` nor `commit_st_we` is asserted, and `exc_cause` shows the stored cause. `exc_valid` lasts exactly one cycle.
- R9: `alloc_ready` is 0 in the cycle that `flush` is 1, and a request made in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_dst | input | REG_AW | Destination register |
| alloc_wr | input | 1 | Instruction writes a register |
| alloc_st | input | 1 | Instruction is a store |
| alloc_pc | input | PC_W | Instruction address |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag of the slot taken |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | log2(DEPTH) | Slot of the result |
| wb_data | input | DATA_W | Result or store data |
| wb_aux | input | PC_W | Branch target or store address |
| wb_mispred | input | 1 | Branch went the wrong way |
| wb_exc | input | 1 | Instruction faulted |
| wb_cause | input | CAUSE_W | Fault cause |
| fwd_tag | input | log2(DEPTH) | Operand lookup slot |
| fwd_valid | output | 1 | Looked-up result is present |
| fwd_data | output | DATA_W | Looked-up result |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_reg_we | output | 1 | Register file write |
| commit_st_we | output | 1 | Memory store |
| commit_dst | output | REG_AW | Register written |
| commit_data | output | DATA_W | Value written or stored |
| commit_pc | output | PC_W | Address of retiring instruction |
| commit_aux | output | PC_W | Store address or branch target |
| flush | output | 1 | Discard younger work |
| redirect_pc | output | PC_W | New fetch address on flush |
| exc_valid | output | 1 | Fault taken |
| exc_cause | output | CAUSE_W | Cause of the fault taken |

## Verification
The main risk is head/tail pointer damage. It shows up at the ports within one cycle, as a skipped or repeated `alloc_tag` or a premature `alloc_ready` drop. A lost ready bit stalls retirement indefinitely. A stale one makes a freshly allocated slot report `fwd_valid` or retire before its write-back. Flush faults show up in the cycle after `flush`, as leftover younger slots still forwarding or a next tag that is not the slot after the flushed one. Wrong fault priority is visible at once on `redirect_pc` and on the suppressed write enables.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      RK_IDLE     = 2'd0,
      RK_RETIRE   = 2'd1,
      RK_REDIRECT = 2'd2,
      RK_TRAP     = 2'd3
   } retire_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   input  logic                     flush,
   output logic [$clog2(DEPTH)-1:0] wr_idx,
   output logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic                     full,
   output logic                     empty
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rob_ptrs: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PW-1:0] head_q, tail_q, head_d, tail_d, occ;

   always_comb begin
      head_d = head_q + PW'(pop);
      tail_d = flush ? head_d : tail_q + PW'(push);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_d;
         tail_q <= tail_d;
      end
   end

   assign wr_idx = tail_q[IW-1:0];
   assign rd_idx = head_q[IW-1:0];
   assign empty  = (head_q == tail_q);
   assign full   = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
   assign occ    = tail_q - head_q;

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_occupancy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH));
   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
   parameter int DEPTH   = 16,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 32,
   parameter int PC_W    = 32,
   parameter int CAUSE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_en,
   input  logic [$clog2(DEPTH)-1:0] alloc_idx,
   input  logic [REG_AW-1:0]        alloc_dst,
   input  logic                     alloc_wr,
   input  logic                     alloc_st,
   input  logic [PC_W-1:0]          alloc_pc,
   input  logic                     wb_en,
   input  logic [$clog2(DEPTH)-1:0] wb_idx,
   input  logic [DATA_W-1:0]        wb_data,
   input  logic [PC_W-1:0]          wb_aux,
   input  logic                     wb_mis,
   input  logic                     wb_exc,
   input  logic [CAUSE_W-1:0]       wb_cause,
   input  logic                     free_en,
   input  logic                     flush_all,
   input  logic [$clog2(DEPTH)-1:0] head_idx,
   input  logic [$clog2(DEPTH)-1:0] fwd_idx,
   output logic                     h_live,
   output logic [REG_AW-1:0]        h_dst,
   output logic                     h_wr,
   output logic                     h_st,
   output logic [PC_W-1:0]          h_pc,
   output logic [DATA_W-1:0]        h_data,
   output logic [PC_W-1:0]          h_aux,
   output logic                     h_mis,
   output logic                     h_exc,
   output logic [CAUSE_W-1:0]       h_cause,
   output logic                     fwd_hit,
   output logic [DATA_W-1:0]        fwd_data
);
   localparam int IW = $clog2(DEPTH);

   logic               busy_v  [DEPTH];
   logic               ready_v [DEPTH];
   logic [REG_AW-1:0]  dst_v   [DEPTH];
   logic               wr_v    [DEPTH];
   logic               st_v    [DEPTH];
   logic [PC_W-1:0]    pc_v    [DEPTH];
   logic [DATA_W-1:0]  data_v  [DEPTH];
   logic [PC_W-1:0]    aux_v   [DEPTH];
   logic               mis_v   [DEPTH];
   logic               exc_v   [DEPTH];
   logic [CAUSE_W-1:0] cause_v [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic               busy_q, ready_q, wr_q, st_q, mis_q, exc_q;
         logic [REG_AW-1:0]  dst_q;
         logic [PC_W-1:0]    pc_q, aux_q;
         logic [DATA_W-1:0]  data_q;
         logic [CAUSE_W-1:0] cause_q;
         logic               hit_alloc, hit_wb, hit_free;

         assign hit_alloc = alloc_en && (alloc_idx == IW'(g));
         assign hit_wb    = wb_en && (wb_idx == IW'(g)) && busy_q;
         assign hit_free  = free_en && (head_idx == IW'(g));

         always_ff @(posedge clk) begin
            if (!rst_n || flush_all) begin
               busy_q  <= 1'b0;
               ready_q <= 1'b0;
            end else begin
               if (hit_free) begin
                  busy_q  <= 1'b0;
                  ready_q <= 1'b0;
               end
               if (hit_alloc) begin
                  busy_q  <= 1'b1;
                  ready_q <= 1'b0;
               end
               if (hit_wb) begin
                  ready_q <= 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dst_q   <= '0;
               wr_q    <= 1'b0;
               st_q    <= 1'b0;
               pc_q    <= '0;
               data_q  <= '0;
               aux_q   <= '0;
               mis_q   <= 1'b0;
               exc_q   <= 1'b0;
               cause_q <= '0;
            end else begin
               if (hit_alloc) begin
                  dst_q <= alloc_dst;
                  wr_q  <= alloc_wr;
                  st_q  <= alloc_st;
                  pc_q  <= alloc_pc;
                  mis_q <= 1'b0;
                  exc_q <= 1'b0;
               end
               if (hit_wb) begin
                  data_q  <= wb_data;
                  aux_q   <= wb_aux;
                  mis_q   <= wb_mis;
                  exc_q   <= wb_exc;
                  cause_q <= wb_cause;
               end
            end
         end

         assign busy_v[g]  = busy_q;
         assign ready_v[g] = ready_q;
         assign dst_v[g]   = dst_q;
         assign wr_v[g]    = wr_q;
         assign st_v[g]    = st_q;
         assign pc_v[g]    = pc_q;
         assign data_v[g]  = data_q;
         assign aux_v[g]   = aux_q;
         assign mis_v[g]   = mis_q;
         assign exc_v[g]   = exc_q;
         assign cause_v[g] = cause_q;
      end
   endgenerate

   assign h_live   = busy_v[head_idx] && ready_v[head_idx];
   assign h_dst    = dst_v[head_idx];
   assign h_wr     = wr_v[head_idx];
   assign h_st     = st_v[head_idx];
   assign h_pc     = pc_v[head_idx];
   assign h_data   = data_v[head_idx];
   assign h_aux    = aux_v[head_idx];
   assign h_mis    = mis_v[head_idx];
   assign h_exc    = exc_v[head_idx];
   assign h_cause  = cause_v[head_idx];
   assign fwd_hit  = busy_v[fwd_idx] && ready_v[fwd_idx];
   assign fwd_data = data_v[fwd_idx];

   assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !busy_v[alloc_idx]);
   assert_wb_marks_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && busy_v[wb_idx] && !flush_all && !(free_en && head_idx == wb_idx))
      |=> ready_v[$past(wb_idx)]);
   assert_fresh_slot_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !flush_all) |=> !ready_v[$past(alloc_idx)]);
endmodule

// File: rtl/rob_retire.sv
module rob_retire
   import rob_pkg::*;
#(
   parameter int              PC_W        = 32,
   parameter logic [PC_W-1:0] TRAP_VECTOR = '0
) (
   input  logic            h_live,
   input  logic            h_wr,
   input  logic            h_st,
   input  logic            h_mis,
   input  logic            h_exc,
   input  logic [PC_W-1:0] h_aux,
   output retire_kind_e    kind,
   output logic            retire,
   output logic            reg_we,
   output logic            st_we,
   output logic            flush,
   output logic            trap,
   output logic [PC_W-1:0] redirect
);
   always_comb begin
      if (!h_live)    kind = RK_IDLE;
      else if (h_exc) kind = RK_TRAP;
      else if (h_mis) kind = RK_REDIRECT;
      else            kind = RK_RETIRE;
   end

   assign retire   = (kind != RK_IDLE);
   assign reg_we   = (kind == RK_RETIRE || kind == RK_REDIRECT) && h_wr;
   assign st_we    = (kind == RK_RETIRE || kind == RK_REDIRECT) && h_st;
   assign trap     = (kind == RK_TRAP);
   assign flush    = (kind == RK_TRAP) || (kind == RK_REDIRECT);
   assign redirect = (kind == RK_TRAP) ? TRAP_VECTOR : h_aux;
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int                  DEPTH       = 16,
   parameter int                  REG_AW      = 5,
   parameter int                  DATA_W      = 32,
   parameter int                  PC_W        = 32,
   parameter int                  CAUSE_W     = 4,
   parameter logic [PC_W-1:0]     TRAP_VECTOR = PC_W'(32'h0000_0180)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_valid,
   input  logic [REG_AW-1:0]        alloc_dst,
   input  logic                     alloc_wr,
   input  logic                     alloc_st,
   input  logic [PC_W-1:0]          alloc_pc,
   output logic                     alloc_ready,
   output logic [$clog2(DEPTH)-1:0] alloc_tag,
   input  logic                     wb_valid,
   input  logic [$clog2(DEPTH)-1:0] wb_tag,
   input  logic [DATA_W-1:0]        wb_data,
   input  logic [PC_W-1:0]          wb_aux,
   input  logic                     wb_mispred,
   input  logic                     wb_exc,
   input  logic [CAUSE_W-1:0]       wb_cause,
   input  logic [$clog2(DEPTH)-1:0] fwd_tag,
   output logic                     fwd_valid,
   output logic [DATA_W-1:0]        fwd_data,
   output logic                     commit_valid,
   output logic                     commit_reg_we,
   output logic                     commit_st_we,
   output logic [REG_AW-1:0]        commit_dst,
   output logic [DATA_W-1:0]        commit_data,
   output logic [PC_W-1:0]          commit_pc,
   output logic [PC_W-1:0]          commit_aux,
   output logic                     flush,
   output logic [PC_W-1:0]          redirect_pc,
   output logic                     exc_valid,
   output logic [CAUSE_W-1:0]       exc_cause
);
   import rob_pkg::*;
   localparam int IW = $clog2(DEPTH);

   generate
      if (REG_AW < 1 || DATA_W < 1 || PC_W < 1 || CAUSE_W < 1) begin : g_bad_width
         $error("rob_core: all widths must be positive");
      end
   endgenerate

   logic          full, empty, do_alloc;
   logic [IW-1:0] tail_idx, head_idx;
   logic          h_live, h_wr, h_st, h_mis, h_exc;
   logic [PC_W-1:0] h_aux;
   retire_kind_e  kind;

   assign alloc_ready = !full && !flush;
   assign do_alloc    = alloc_valid && alloc_ready;
   assign alloc_tag   = tail_idx;

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (do_alloc),
      .pop    (commit_valid),
      .flush  (flush),
      .wr_idx (tail_idx),
      .rd_idx (head_idx),
      .full   (full),
      .empty  (empty)
   );

   rob_entries #(
      .DEPTH(DEPTH), .REG_AW(REG_AW), .DATA_W(DATA_W), .PC_W(PC_W), .CAUSE_W(CAUSE_W)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (do_alloc),
      .alloc_idx (tail_idx),
      .alloc_dst (alloc_dst),
      .alloc_wr  (alloc_wr),
      .alloc_st  (alloc_st),
      .alloc_pc  (alloc_pc),
      .wb_en     (wb_valid),
      .wb_idx    (wb_tag),
      .wb_data   (wb_data),
      .wb_aux    (wb_aux),
      .wb_mis    (wb_mispred),
      .wb_exc    (wb_exc),
      .wb_cause  (wb_cause),
      .free_en   (commit_valid),
      .flush_all (flush),
      .head_idx  (head_idx),
      .fwd_idx   (fwd_tag),
      .h_live    (h_live),
      .h_dst     (commit_dst),
      .h_wr      (h_wr),
      .h_st      (h_st),
      .h_pc      (commit_pc),
      .h_data    (commit_data),
      .h_aux     (h_aux),
      .h_mis     (h_mis),
      .h_exc     (h_exc),
      .h_cause   (exc_cause),
      .fwd_hit   (fwd_valid),
      .fwd_data  (fwd_data)
   );

   assign commit_aux = h_aux;

   rob_retire #(.PC_W(PC_W), .TRAP_VECTOR(TRAP_VECTOR)) u_retire (
      .h_live   (h_live),
      .h_wr     (h_wr),
      .h_st     (h_st),
      .h_mis    (h_mis),
      .h_exc    (h_exc),
      .h_aux    (h_aux),
      .kind     (kind),
      .retire   (commit_valid),
      .reg_we   (commit_reg_we),
      .st_we    (commit_st_we),
      .flush    (flush),
      .trap     (exc_valid),
      .redirect (redirect_pc)
   );

   assert_empty_no_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !commit_valid && !fwd_valid);
   assert_trap_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!commit_reg_we && !commit_st_we && flush));
   assert_trap_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> !exc_valid);
   assert_no_issue_on_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ready);
   assert_redirect_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !exc_valid) |-> (redirect_pc == commit_aux));
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
   localparam int D   = 4;
   localparam int IW  = 2;
   localparam logic [31:0] TV = 32'h0000_0180;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          alloc_valid = 0, alloc_wr = 0, alloc_st = 0;
   logic [4:0]    alloc_dst = '0;
   logic [31:0]   alloc_pc = '0;
   logic          alloc_ready;
   logic [IW-1:0] alloc_tag;
   logic          wb_valid = 0, wb_mispred = 0, wb_exc = 0;
   logic [IW-1:0] wb_tag = '0, fwd_tag = '0;
   logic [31:0]   wb_data = '0, wb_aux = '0;
   logic [3:0]    wb_cause = '0;
   logic          fwd_valid, commit_valid, commit_reg_we, commit_st_we, flush, exc_valid;
   logic [31:0]   fwd_data, commit_data, commit_pc, commit_aux, redirect_pc;
   logic [4:0]    commit_dst;
   logic [3:0]    exc_cause;

   rob_core #(.DEPTH(D), .TRAP_VECTOR(TV)) u0 (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic ck(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic put_alloc(input logic [4:0] dst, input logic wr, input logic st,
                            input logic [31:0] pc, input int exp_tag, input string req);
      alloc_valid = 1; alloc_dst = dst; alloc_wr = wr; alloc_st = st; alloc_pc = pc;
      #1;
      ck({req, " alloc_ready"}, alloc_ready, 1);
      ck({req, " alloc_tag"}, alloc_tag, exp_tag % D);
      step();
      alloc_valid = 0;
   endtask

   task automatic put_wb(input int tag, input logic [31:0] data, input logic [31:0] aux,
                         input logic mis, input logic exc, input logic [3:0] cause);
      wb_valid = 1; wb_tag = IW'(tag % D); wb_data = data; wb_aux = aux;
      wb_mispred = mis; wb_exc = exc; wb_cause = cause;
      step();
      wb_valid = 0; wb_mispred = 0; wb_exc = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base = 0;
      repeat (3) step();
      rst_n = 1;
      #1;
      // R1 reset state
      ck("R1 alloc_ready", alloc_ready, 1);
      ck("R1 alloc_tag", alloc_tag, 0);
      ck("R1 commit_valid", commit_valid, 0);
      ck("R1 flush", flush, 0);
      ck("R1 exc_valid", exc_valid, 0);
      for (int t = 0; t < D; t++) begin
         fwd_tag = IW'(t); #1;
         ck("R1 fwd_valid", fwd_valid, 0);
      end

      // Sweep of fill levels across wraps: R2 R3 R4 R5 R6
      for (int r = 0; r < 8; r++) begin
         int n = (r % D) + 1;
         for (int i = 0; i < n; i++)
            put_alloc(5'(r + i + 1), 1'b1, 1'b0, 32'(1000 + r * 64 + i * 4), base + i, "R2");
         if (n == D) begin
            #1;
            ck("R2 full alloc_ready", alloc_ready, 0);
            alloc_valid = 1; step(); alloc_valid = 0;
         end
         for (int i = n - 1; i >= 0; i--) begin
            put_wb(base + i, 32'(32'h100 * r + i * 3 + 7), 32'hA0 + 32'(i), 0, 0, 0);
            if (i > 0) begin
               fwd_tag = IW'((base + i) % D); #1;
               ck("R4 younger waits", commit_valid, 0);
               ck("R6 fwd_valid", fwd_valid, 1);
               ck("R6 fwd_data", fwd_data, 32'(32'h100 * r + i * 3 + 7));
               if (i > 1) begin
                  fwd_tag = IW'((base + i - 1) % D); #1;
                  ck("R6 unwritten fwd_valid", fwd_valid, 0);
               end
            end
         end
         for (int i = 0; i < n; i++) begin
            #1;
            ck("R4 commit_valid", commit_valid, 1);
            ck("R5 commit_reg_we", commit_reg_we, 1);
            ck("R5 commit_st_we", commit_st_we, 0);
            ck("R5 commit_dst", commit_dst, 5'(r + i + 1));
            ck("R5 commit_data", commit_data, 32'(32'h100 * r + i * 3 + 7));
            ck("R5 commit_pc", commit_pc, 32'(1000 + r * 64 + i * 4));
            ck("R5 commit_aux", commit_aux, 32'hA0 + 32'(i));
            step();
         end
         ck("R4 drained", commit_valid, 0);
         base += n;
      end

      // R3: write-back to a free slot is ignored; R5 store retirement
      put_wb(base, 32'hDEAD, 32'h0, 0, 0, 0);
      fwd_tag = IW'(base % D); #1;
      ck("R3 free slot not ready", fwd_valid, 0);
      put_alloc(5'd0, 1'b0, 1'b1, 32'h2000, base, "R3");
      fwd_tag = IW'(base % D); #1;
      ck("R3 stale wb after alloc", fwd_valid, 0);
      ck("R3 no early commit", commit_valid, 0);
      put_wb(base, 32'h5A5A, 32'h8040, 0, 0, 0);
      #1;
      ck("R5 store commit", commit_valid, 1);
      ck("R5 store st_we", commit_st_we, 1);
      ck("R5 store reg_we", commit_reg_we, 0);
      ck("R5 store address", commit_aux, 32'h8040);
      ck("R5 store data", commit_data, 32'h5A5A);
      step();
      base += 1;

      // R7 R9 wrong-path branch at head
      put_alloc(5'd7, 1'b1, 1'b0, 32'h3000, base, "R7");
      put_alloc(5'd8, 1'b1, 1'b0, 32'h3004, base + 1, "R7");
      put_alloc(5'd9, 1'b1, 1'b0, 32'h3008, base + 2, "R7");
      put_wb(base + 2, 32'h33, 32'h0, 0, 0, 0);
      put_wb(base + 1, 32'h22, 32'h0, 0, 0, 0);
      put_wb(base, 32'h11, 32'h4444, 1, 0, 0);
      alloc_valid = 1; #1;
      ck("R7 flush", flush, 1);
      ck("R7 redirect_pc", redirect_pc, 32'h4444);
      ck("R7 branch reg_we", commit_reg_we, 1);
      ck("R7 exc_valid", exc_valid, 0);
      ck("R9 alloc_ready during flush", alloc_ready, 0);
      step();
      alloc_valid = 0;
      fwd_tag = IW'((base + 1) % D); #1;
      ck("R7 younger discarded", fwd_valid, 0);
      ck("R7 nothing retires", commit_valid, 0);
      ck("R7 flush dropped", flush, 0);
      ck("R9 next tag after flush", alloc_tag, (base + 1) % D);
      ck("R7 alloc_ready after flush", alloc_ready, 1);
      base += 1;

      // R8 fault with wrong-path flag also set
      put_alloc(5'd3, 1'b1, 1'b1, 32'h5000, base, "R8");
      put_alloc(5'd4, 1'b1, 1'b0, 32'h5004, base + 1, "R8");
      put_wb(base + 1, 32'h77, 32'h0, 0, 0, 0);
      put_wb(base, 32'h66, 32'h9999, 1, 1, 4'd5);
      #1;
      ck("R8 exc_valid", exc_valid, 1);
      ck("R8 exc_cause", exc_cause, 5);
      ck("R8 flush", flush, 1);
      ck("R8 redirect to trap vector", redirect_pc, TV);
      ck("R8 reg_we suppressed", commit_reg_we, 0);
      ck("R8 st_we suppressed", commit_st_we, 0);
      step();
      fwd_tag = IW'((base + 1) % D); #1;
      ck("R8 one cycle", exc_valid, 0);
      ck("R8 younger discarded", fwd_valid, 0);
      ck("R8 next tag", alloc_tag, (base + 1) % D);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule